// File: doc/BRIEF.md
# Banked Memory Window Address Translator

This block lets a host address a large on-card buffer memory with linear addresses, even though the memory is only reachable through a small window whose position is chosen by a bank-select register. Each request carries a base byte address and a word offset. Because the data path is 16 bits wide, the offset counts words, so the block doubles it and adds the base to form a byte address. It then splits that byte address into a bank number (the bits above the window) and a window offset (the low bits).

The block keeps a copy of the bank most recently programmed. A request whose bank matches that copy goes straight to the memory port. A request that needs a different bank first spends one cycle writing the bank-select register, then goes to the memory port. A bank number at or beyond the configured bank count is reported on a flag, and that request is dropped. Reset and an explicit initialise pulse both program bank 0. A debug flag reports odd window offsets, which a word access should never produce.

Requests arrive on a valid/ready stream and accesses leave on a valid/ready stream. The host may hold `req_valid` with a stable payload for as long as `req_ready` is low. Once the memory port raises `mem_valid`, it holds that signal and its payload steady until `mem_ready` is seen high at a clock edge. Only one request is in flight at a time, and no new request is accepted until the current access has been taken.

Top module: `bankwin_xlat`

## Requirements
- R1: The byte address is `req_base + 2*req_woff`, computed without loss of the carry. `mem_off` carries its low WIN_W (13) bits, and the bank number is the byte address shifted right by WIN_W.
- R2: If an accepted request's bank equals the cached bank, `mem_valid` rises in the cycle after acceptance and `bank_we` stays low.
- R3: If an accepted request's bank differs from the cached bank, `bank_we` is high for exactly the cycle after acceptance, with `bank_wdata` = {enable bit 1 in the MSB, bank number in the low bits}. `mem_valid` is low in that cycle and rises in the next one. The cache then holds the new bank.
- R4: After reset is released, the first clock edge leads to one cycle of `bank_we` with `bank_wdata` equal to the enable bit over bank 0. `req_ready` is low until that write is done, and the cached bank is 0.
- R5: A cycle with `init_i` high makes `req_ready` low in that cycle, even if `req_valid` is high, so initialisation wins. The next cycle carries a `bank_we` of enable over bank 0, and the cached bank becomes 0.
- R6: When an accepted request's window offset is odd, `odd_flag` is high for the single cycle after acceptance and the access is still issued. Otherwise `odd_flag` stays low.
- R7: When an accepted request's bank number is NBANK or more, `oor_flag` is high for the single cycle after acceptance. No `bank_we` or `mem_valid` follows for that request, and the cached bank is unchanged.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_off`, `mem_we` and `mem_wdata` hold their values and `req_ready` stays low. `mem_valid` falls in the cycle after it is taken.
- R9: An `init_i` pulse that arrives while a request is in flight is remembered. Once the access is taken, the block returns to idle with `req_ready` low, and the following cycle carries the bank-0 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Initialise: program bank 0 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_base | input | ADDR_W | Base byte address |
| req_woff | input | WOFF_W | Offset in 16-bit words |
| req_we | input | 1 | Request is a write |
| req_wdata | input | DATA_W | Write data |
| mem_valid | output | 1 | Window access valid |
| mem_ready | input | 1 | Window access taken |
| mem_off | output | WIN_W | Byte offset inside the window |
| mem_we | output | 1 | Access is a write |
| mem_wdata | output | DATA_W | Write data of the access |
| bank_we | output | 1 | Bank-select register write strobe |
| bank_wdata | output | BANK_W+1 | Enable bit (MSB) and bank number |
| odd_flag | output | 1 | Debug: odd window offset seen |
| oor_flag | output | 1 | Bank number out of range, request dropped |

## Verification
Initialisation and request acceptance can fall in the same cycle. The bench raises `init_i` while a request is already valid and checks three things: `req_ready` is low in that cycle, the bank-0 write follows, and the waiting request is then served as a bank-0 hit with no further write. An initialise pulse can also land while an access is stalled on `mem_ready`. The bench checks that the stalled access is completed unchanged and that the bank-0 write follows it. Random requests clustered near bank boundaries mix hits, misses, odd offsets and out-of-range banks, and each outcome is judged against a bench model of the cached bank.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

  typedef enum logic [1:0] {
    BW_IDLE  = 2'd0,
    BW_INIT  = 2'd1,
    BW_BANK  = 2'd2,
    BW_ISSUE = 2'd3
  } bw_state_e;

  function automatic int bw_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bankwin_split.sv
module bankwin_split #(
  parameter int ADDR_W = 17,
  parameter int WOFF_W = 16,
  parameter int WIN_W  = 13,
  parameter int NBANK  = 16,
  parameter int BA_W   = 18,
  parameter int BANK_W = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [WOFF_W-1:0] woff,
  output logic [BANK_W-1:0] bank,
  output logic [WIN_W-1:0]  off,
  output logic              odd,
  output logic              oor
);
  localparam int BSEL_W = BA_W - WIN_W;

  logic [BA_W-1:0]   byte_addr;
  logic [BSEL_W-1:0] bank_full;

  // word offset scaled to bytes, added with carry room
  assign byte_addr = BA_W'(base) + BA_W'({woff, 1'b0});
  assign bank_full = byte_addr[BA_W-1:WIN_W];
  assign off       = byte_addr[WIN_W-1:0];
  assign odd       = byte_addr[0];
  assign oor       = (32'(bank_full) >= 32'(NBANK));

  generate
    if (BSEL_W >= BANK_W) begin : g_trunc
      assign bank = bank_full[BANK_W-1:0];
    end else begin : g_extend
      assign bank = BANK_W'(bank_full);
    end
  endgenerate

endmodule

// File: rtl/bankwin_cache.sv
module bankwin_cache #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] load_bank,
  input  logic [BANK_W-1:0] req_bank,
  output logic              hit
);
  logic [BANK_W-1:0] cur_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bank <= '0;
    end else if (load) begin
      cur_bank <= load_bank;
    end
  end

  assign hit = (req_bank == cur_bank);

endmodule

// File: rtl/bankwin_ctrl.sv
module bankwin_ctrl
  import bankwin_pkg::*;
#(
  parameter int WIN_W  = 13,
  parameter int DATA_W = 16,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BANK_W-1:0] sp_bank,
  input  logic [WIN_W-1:0]  sp_off,
  input  logic              sp_odd,
  input  logic              sp_oor,
  input  logic              hit,
  output logic              cache_load,
  output logic [BANK_W-1:0] cache_bank,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [WIN_W-1:0]  mem_off,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              odd_flag,
  output logic              oor_flag
);
  bw_state_e         st;
  logic              init_pend;
  logic [BANK_W-1:0] hold_bank;
  logic [WIN_W-1:0]  hold_off;
  logic              hold_we;
  logic [DATA_W-1:0] hold_wdata;
  logic              odd_q;
  logic              oor_q;
  logic              accept;

  assign req_ready = (st == BW_IDLE) && !init_pend && !init_i;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= BW_IDLE;
      init_pend  <= 1'b1;
      hold_bank  <= '0;
      hold_off   <= '0;
      hold_we    <= 1'b0;
      hold_wdata <= '0;
      odd_q      <= 1'b0;
      oor_q      <= 1'b0;
    end else begin
      odd_q <= 1'b0;
      oor_q <= 1'b0;
      unique case (st)
        BW_IDLE: begin
          if (init_i || init_pend) begin
            st        <= BW_INIT;
            init_pend <= 1'b0;
          end else if (accept) begin
            if (sp_oor) begin
              oor_q <= 1'b1;
            end else begin
              hold_bank  <= sp_bank;
              hold_off   <= sp_off;
              hold_we    <= req_we;
              hold_wdata <= req_wdata;
              odd_q      <= sp_odd;
              st         <= hit ? BW_ISSUE : BW_BANK;
            end
          end
        end
        BW_INIT: begin
          st <= BW_IDLE;
        end
        BW_BANK: begin
          st <= BW_ISSUE;
          if (init_i) init_pend <= 1'b1;
        end
        BW_ISSUE: begin
          if (mem_ready) st <= BW_IDLE;
          if (init_i) init_pend <= 1'b1;
        end
        default: st <= BW_IDLE;
      endcase
    end
  end

  assign cache_load = (st == BW_INIT) || (st == BW_BANK);
  assign cache_bank = (st == BW_BANK) ? hold_bank : '0;
  assign mem_valid  = (st == BW_ISSUE);
  assign mem_off    = hold_off;
  assign mem_we     = hold_we;
  assign mem_wdata  = hold_wdata;
  assign odd_flag   = odd_q;
  assign oor_flag   = oor_q;

endmodule

// File: rtl/bankwin_xlat.sv
module bankwin_xlat
  import bankwin_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int WOFF_W = 16,
  parameter int DATA_W = 16,
  parameter int WIN_W  = 13,
  parameter int NBANK  = 16,
  localparam int BA_W   = bw_max(ADDR_W, WOFF_W + 1) + 1,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int BREG_W = BANK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [WOFF_W-1:0] req_woff,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [WIN_W-1:0]  mem_off,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              bank_we,
  output logic [BREG_W-1:0] bank_wdata,
  output logic              odd_flag,
  output logic              oor_flag
);
  logic [BANK_W-1:0] sp_bank;
  logic [WIN_W-1:0]  sp_off;
  logic              sp_odd;
  logic              sp_oor;
  logic              hit;
  logic              cache_load;
  logic [BANK_W-1:0] cache_bank;

  bankwin_split #(
    .ADDR_W(ADDR_W), .WOFF_W(WOFF_W), .WIN_W(WIN_W),
    .NBANK(NBANK), .BA_W(BA_W), .BANK_W(BANK_W)
  ) u_split (
    .base(req_base), .woff(req_woff),
    .bank(sp_bank), .off(sp_off), .odd(sp_odd), .oor(sp_oor)
  );

  bankwin_cache #(.BANK_W(BANK_W)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .load(cache_load), .load_bank(cache_bank),
    .req_bank(sp_bank), .hit(hit)
  );

  bankwin_ctrl #(.WIN_W(WIN_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .init_i(init_i),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_wdata(req_wdata),
    .sp_bank(sp_bank), .sp_off(sp_off), .sp_odd(sp_odd), .sp_oor(sp_oor),
    .hit(hit), .cache_load(cache_load), .cache_bank(cache_bank),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_off(mem_off), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .odd_flag(odd_flag), .oor_flag(oor_flag)
  );

  // the enable bit rides above the bank number on every register write
  assign bank_we    = cache_load;
  assign bank_wdata = {1'b1, cache_bank};

endmodule

// File: rtl/bankwin_checker.sv
module bankwin_checker #(
  parameter int WIN_W  = 13,
  parameter int DATA_W = 16,
  parameter int BREG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_i,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [WIN_W-1:0]  mem_off,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              bank_we,
  input logic [BREG_W-1:0] bank_wdata,
  input logic              odd_flag,
  input logic              oor_flag
);
  // R3: every register write carries the enable bit
  p_enable_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> bank_wdata[BREG_W-1]);

  // R3: a bank write never overlaps an access
  p_write_before_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> !mem_valid);

  // R2: an accepted request produces a write, an access or a range flag next
  p_accept_acts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bank_we || mem_valid || oor_flag));

  // R5: initialise wins over acceptance
  p_init_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |-> !req_ready);

  // R7: a dropped request issues nothing
  p_oor_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oor_flag |-> (!mem_valid && !bank_we && !odd_flag));

  // R8: a stalled access holds its payload
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_off) && $stable(mem_we) && $stable(mem_wdata)));

  // R8: no acceptance while an access is outstanding
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

endmodule

bind bankwin_xlat bankwin_checker #(
  .WIN_W(WIN_W), .DATA_W(DATA_W), .BREG_W(BREG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_i(init_i),
  .req_valid(req_valid), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_off(mem_off), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .bank_we(bank_we), .bank_wdata(bank_wdata),
  .odd_flag(odd_flag), .oor_flag(oor_flag)
);

// File: tb/bankwin_xlat_bench.sv
module bankwin_xlat_bench;
  localparam int ADDR_W = 17;
  localparam int WOFF_W = 16;
  localparam int DATA_W = 16;
  localparam int WIN_W  = 13;
  localparam int NBANK  = 16;
  localparam int BANK_W = 4;
  localparam int BREG_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              init_i = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_base = '0;
  logic [WOFF_W-1:0] req_woff = '0;
  logic              req_we = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              mem_valid;
  logic              mem_ready = 1'b0;
  logic [WIN_W-1:0]  mem_off;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic              bank_we;
  logic [BREG_W-1:0] bank_wdata;
  logic              odd_flag;
  logic              oor_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int model_bank = 0;

  always #10 clk = ~clk;

  bankwin_xlat #(
    .ADDR_W(ADDR_W), .WOFF_W(WOFF_W), .DATA_W(DATA_W),
    .WIN_W(WIN_W), .NBANK(NBANK)
  ) u_bankwin_xlat (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_bank(input logic [ADDR_W-1:0] b, input logic [WOFF_W-1:0] w);
    logic [17:0] ba;
    ba = 18'(b) + 18'({w, 1'b0});
    return int'(ba[17:13]);
  endfunction

  function automatic int exp_off(input logic [ADDR_W-1:0] b, input logic [WOFF_W-1:0] w);
    logic [17:0] ba;
    ba = 18'(b) + 18'({w, 1'b0});
    return int'(ba[12:0]);
  endfunction

  function automatic int bank_word(input int bank);
    return (1 << BANK_W) | bank;
  endfunction

  // called at a negedge; returns at a negedge with the block idle
  task automatic do_req(input logic [ADDR_W-1:0] b, input logic [WOFF_W-1:0] w,
                        input bit we, input logic [DATA_W-1:0] d, input int stall);
    int bk, of;
    int guard = 0;
    bk = exp_bank(b, w);
    of = exp_off(b, w);
    while (!req_ready && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b1; req_base = b; req_woff = w; req_we = we; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (bk >= NBANK) begin
      chk(oor_flag == 1'b1, "R7 oor_flag", int'(oor_flag), 1);
      chk(!mem_valid && !bank_we, "R7 no access", int'({mem_valid, bank_we}), 0);
      return;
    end
    chk(oor_flag == 1'b0, "R7 in-range flag low", int'(oor_flag), 0);
    chk(odd_flag == of[0], "R6 odd_flag", int'(odd_flag), of & 1);
    if (bk != model_bank) begin
      chk(bank_we && int'(bank_wdata) == bank_word(bk), "R3 bank write",
          int'({bank_we, bank_wdata}), (1 << BREG_W) | bank_word(bk));
      chk(!mem_valid, "R3 stall cycle", int'(mem_valid), 0);
      model_bank = bk;
      @(negedge clk);
    end else begin
      chk(!bank_we, "R2 no write on hit", int'(bank_we), 0);
    end
    chk(mem_valid == 1'b1, "R2 access issued", int'(mem_valid), 1);
    chk(int'(mem_off) == of, "R1 window offset", int'(mem_off), of);
    chk(mem_we == we && mem_wdata == d, "R1 payload",
        int'({mem_we, mem_wdata}), int'({we, d}));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_valid && int'(mem_off) == of && mem_wdata == d, "R8 hold",
          int'(mem_off), of);
      chk(!req_ready, "R8 not ready while busy", int'(req_ready), 0);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(!mem_valid, "R8 valid drops after take", int'(mem_valid), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5A17));

    // R4: reset
    repeat (3) @(negedge clk);
    chk(!bank_we && !mem_valid && !req_ready, "R4 quiet in reset",
        int'({bank_we, mem_valid, req_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bank_we && int'(bank_wdata) == bank_word(0), "R4 bank 0 after reset",
        int'({bank_we, bank_wdata}), (1 << BREG_W) | bank_word(0));
    chk(!req_ready, "R4 not ready during write", int'(req_ready), 0);
    @(negedge clk);
    chk(req_ready, "R4 ready after write", int'(req_ready), 1);
    model_bank = 0;

    // directed corners
    do_req(17'h01FFE, 16'h0000, 1'b1, 16'hA5A5, 0);  // R2 hit bank 0, top of window
    do_req(17'h01FFE, 16'h0001, 1'b1, 16'h1234, 2);  // R3 crosses into bank 1
    do_req(17'h02000, 16'h0010, 1'b0, 16'h0000, 0);  // R2 hit bank 1
    do_req(17'h00003, 16'h0002, 1'b0, 16'h0000, 1);  // R6 odd, back to bank 0
    do_req(17'h1FFFE, 16'hFFFF, 1'b1, 16'h0F0F, 0);  // R7 far out of range
    do_req(17'h00000, 16'h0100, 1'b0, 16'h0000, 0);  // R7 cache kept: hit bank 0
    do_req(17'h1E000, 16'h0FFF, 1'b1, 16'h7777, 0);  // R3 last bank 15
    do_req(17'h1E000, 16'h1000, 1'b1, 16'h8888, 0);  // R7 bank 16 just out

    // R5: init in the same cycle as a valid request
    req_valid = 1'b1; req_base = 17'h00010; req_woff = 16'h0000;
    req_we = 1'b0; req_wdata = '0;
    init_i = 1'b1;
    #1;
    chk(!req_ready, "R5 init blocks accept", int'(req_ready), 0);
    @(negedge clk);
    init_i = 1'b0;
    chk(bank_we && int'(bank_wdata) == bank_word(0), "R5 bank 0 write",
        int'({bank_we, bank_wdata}), (1 << BREG_W) | bank_word(0));
    model_bank = 0;
    req_valid = 1'b0;
    @(negedge clk);
    do_req(17'h00010, 16'h0000, 1'b0, 16'h0000, 0);  // R5 hit after init

    // R9: init during a stalled access
    do_req(17'h08000, 16'h0000, 1'b0, 16'h0000, 0);  // move to bank 4
    req_valid = 1'b1; req_base = 17'h08004; req_woff = 16'h0001;
    req_we = 1'b1; req_wdata = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
    chk(mem_valid && int'(mem_off) == 6 && !bank_we, "R9 access kept",
        int'({mem_valid, bank_we, mem_off}), int'({1'b1, 1'b0, 13'd6}));
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(!mem_valid && !req_ready, "R9 idle but blocked",
        int'({mem_valid, req_ready}), 0);
    @(negedge clk);
    chk(bank_we && int'(bank_wdata) == bank_word(0), "R9 deferred bank 0 write",
        int'({bank_we, bank_wdata}), (1 << BREG_W) | bank_word(0));
    model_bank = 0;
    @(negedge clk);

    // random traffic near bank boundaries
    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] b;
      logic [WOFF_W-1:0] w;
      int mode;
      mode = int'($urandom % 4);
      b = ADDR_W'($urandom);
      if (mode == 0) w = WOFF_W'($urandom);
      else if (mode == 1) begin
        b = ADDR_W'(($urandom % 16) << 13) + ADDR_W'($urandom % 8) - 17'd4;
        w = WOFF_W'($urandom % 4);
      end else w = WOFF_W'($urandom % 2048);
      do_req(b, w, 1'($urandom), DATA_W'($urandom), int'($urandom % 3));
    end

    finish_run();
  end

endmodule